// File: doc/BRIEF.md
# Cycles-Per-Task Sampling Monitor

This unit sits beside one SIMD core and measures how well the core's current width and depth setting performs. It frames one sampling interval, measured in completed tasks rather than in a fixed number of clock cycles. An interval opens on a start pulse issued once the core has been reconfigured. The unit then counts task completions until it has seen a per-thread quota for every active thread. At that point it asks the core to drain, so that each thread parks as soon as its current task ends. When every thread reports idle, the unit divides the elapsed cycles by the completed tasks and reports the quotient. A lower quotient means a better setting. The search that consumes this figure lives elsewhere.

Before an interval opens, the unit checks whether the loop holds enough work for the search to make sense. If the loop is too small to fill a minimum number of intervals, no interval runs. The unit instead flags that the default arrangement of two warps, each eight lanes wide, should be applied. The division is done by a multi-cycle restoring divider, and the done pulse appears only once the quotient is final.

Top module: `cpt_monitor`

## Requirements
- R1: After reset, drain_req, interval_done and use_default are 0 and cycles_per_task is 0.
- R2: On an accepted start, the threshold is latched as 2 × active_threads. drain_req becomes 1 on the cycle after the edge at which the running completion count, including that edge's task_done, reaches the threshold. It stays 0 before that edge.
- R3: task_done pulses that arrive while drain_req is 1 are added to the task count. This includes a pulse in the same cycle that all_idle ends the drain. drain_req stays 1 until that cycle and is 0 afterwards.
- R4: The cycle count equals the number of rising edges from the one after the accepted start up to and including the edge at which all_idle is seen during the drain.
- R5: all_idle has no effect before drain_req is 1. It does not end the interval, and the reported value is unchanged by it.
- R6: cycles_per_task equals floor(cycle count / task count).
- R7: interval_done is a single-cycle pulse. It becomes 1 exactly CYC_W+1 edges after the edge at which all_idle ended the drain, and cycles_per_task is already valid in that cycle.
- R8: A start with active_threads = 0, or with loop_tasks < 30 × 2 × active_threads, runs no interval. On the next cycle the unit pulses interval_done and sets use_default to 1 (meaning two 8-wide warps), with cycles_per_task = 0 and no drain. use_default returns to 0 on the next start that runs an interval. loop_tasks = 60 × active_threads exactly does run an interval.
- R9: A start pulse while an interval is running is ignored. The latched threshold does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens an interval after reconfiguration |
| active_threads | input | THREAD_W | Threads active in the new setting |
| loop_tasks | input | LOOP_W | Total tasks in the current parallel loop |
| task_done | input | 1 | One task completed this cycle |
| all_idle | input | 1 | Every thread is parked |
| drain_req | output | 1 | Threads should park after their current task |
| interval_done | output | 1 | Result or default decision is ready |
| use_default | output | 1 | Apply the default two 8-wide warp arrangement |
| cycles_per_task | output | CYC_W | Elapsed cycles divided by completed tasks |

## Verification
Two events can fall in one cycle: the last task completion of a drain and the all_idle that closes it. Another pair is the completion that crosses the threshold together with an all_idle still asserted from the running phase. The sweep drives task_done in the very cycle all_idle is raised, and it holds all_idle high during the first running cycle. It then judges the outcome from the reported quotient and the drain timing. A stray start during a running interval is also placed next to completion pulses, and the bench confirms that the threshold it observes through drain_req still comes from the first start.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DIV   = 2'd3
  } cpt_state_e;
endpackage

// File: rtl/cpt_gate.sv
// Start-time decision: the task threshold of the interval and whether the
// loop is too small to adapt at all.
module cpt_gate #(
  parameter int THREAD_W         = 4,
  parameter int LOOP_W           = 16,
  parameter int TASK_W           = 8,
  parameter int TASKS_PER_THREAD = 2,
  parameter int MIN_INTERVALS    = 30
) (
  input  logic [THREAD_W-1:0] threads,
  input  logic [LOOP_W-1:0]   loop_tasks,
  output logic [TASK_W-1:0]   threshold,
  output logic                use_dflt
);
  localparam int LOOP_SCALE = MIN_INTERVALS * TASKS_PER_THREAD;

  logic [31:0] need;
  logic [31:0] per_iv;

  always_comb begin
    per_iv    = 32'(TASKS_PER_THREAD) * 32'(threads);
    need      = 32'(LOOP_SCALE) * 32'(threads);
    threshold = TASK_W'(per_iv);
    use_dflt  = (threads == '0) || (32'(loop_tasks) < need);
  end
endmodule

// File: rtl/cpt_divider.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per result.
module cpt_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             valid,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy;
  logic [CNT_W-1:0] step;
  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W:0]   rem_sh;
  logic             fits;

  always_comb begin
    rem_sh = {rem[DEN_W-1:0], q[NUM_W-1]};
    fits   = rem_sh >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      rem   <= '0;
      q     <= '0;
      den_q <= '0;
      num_q <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        step  <= '0;
        rem   <= '0;
        q     <= num;
        num_q <= num;
        den_q <= den;
      end else if (busy) begin
        if (fits) begin
          rem <= rem_sh - {1'b0, den_q};
          q   <= {q[NUM_W-2:0], 1'b1};
        end else begin
          rem <= rem_sh;
          q   <= {q[NUM_W-2:0], 1'b0};
        end
        step <= step + 1'b1;
        if (step == CNT_W'(NUM_W - 1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quot = q;

  // R6: the quotient is the floor of the latched dividend over divisor
  assert_quotient_floor_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((64'(quot) * 64'(den_q) <= 64'(num_q)) &&
               (64'(quot) * 64'(den_q) + 64'(den_q) > 64'(num_q))));

  // R6: a division never starts with a zero divisor
  assert_nonzero_divisor_R6: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |-> (den != '0));
endmodule

// File: rtl/cpt_monitor.sv
module cpt_monitor #(
  parameter int THREAD_W         = 4,
  parameter int TASK_W           = 8,
  parameter int CYC_W            = 16,
  parameter int LOOP_W           = 16,
  parameter int TASKS_PER_THREAD = 2,
  parameter int MIN_INTERVALS    = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [THREAD_W-1:0] active_threads,
  input  logic [LOOP_W-1:0]   loop_tasks,
  input  logic                task_done,
  input  logic                all_idle,
  output logic                drain_req,
  output logic                interval_done,
  output logic                use_default,
  output logic [CYC_W-1:0]    cycles_per_task
);
  import cpt_pkg::*;

  cpt_state_e        state;
  logic [TASK_W-1:0] thr_q;
  logic [TASK_W-1:0] task_cnt;
  logic [CYC_W-1:0]  cyc_cnt;
  logic              drain_q;
  logic              done_q;
  logic              fb_q;
  logic [CYC_W-1:0]  cpt_q;

  logic [TASK_W-1:0] thr_new;
  logic              dflt_new;
  logic [TASK_W-1:0] task_nxt;
  logic [CYC_W-1:0]  cyc_nxt;
  logic              div_go;
  logic              div_valid;
  logic [CYC_W-1:0]  div_quot;

  cpt_gate #(
    .THREAD_W(THREAD_W), .LOOP_W(LOOP_W), .TASK_W(TASK_W),
    .TASKS_PER_THREAD(TASKS_PER_THREAD), .MIN_INTERVALS(MIN_INTERVALS)
  ) u_gate (
    .threads(active_threads), .loop_tasks(loop_tasks),
    .threshold(thr_new), .use_dflt(dflt_new)
  );

  always_comb begin
    task_nxt = task_cnt + TASK_W'(task_done && (task_cnt != '1));
    cyc_nxt  = cyc_cnt + CYC_W'(cyc_cnt != '1);
    div_go   = (state == ST_DRAIN) && all_idle;
  end

  cpt_divider #(.NUM_W(CYC_W), .DEN_W(TASK_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .num(cyc_nxt), .den(task_nxt),
    .valid(div_valid), .quot(div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      thr_q    <= '0;
      task_cnt <= '0;
      cyc_cnt  <= '0;
      drain_q  <= 1'b0;
      done_q   <= 1'b0;
      fb_q     <= 1'b0;
      cpt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (dflt_new) begin
            fb_q   <= 1'b1;
            done_q <= 1'b1;
            cpt_q  <= '0;
          end else begin
            fb_q     <= 1'b0;
            thr_q    <= thr_new;
            task_cnt <= '0;
            cyc_cnt  <= '0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          cyc_cnt  <= cyc_nxt;
          task_cnt <= task_nxt;
          if (task_nxt >= thr_q) begin
            state   <= ST_DRAIN;
            drain_q <= 1'b1;
          end
        end
        ST_DRAIN: begin
          cyc_cnt  <= cyc_nxt;
          task_cnt <= task_nxt;
          if (all_idle) begin
            state   <= ST_DIV;
            drain_q <= 1'b0;
          end
        end
        ST_DIV: if (div_valid) begin
          cpt_q  <= div_quot;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign drain_req       = drain_q;
  assign interval_done   = done_q;
  assign use_default     = fb_q;
  assign cycles_per_task = cpt_q;

  // R2: a drain is only requested once the quota has been met
  assert_drain_after_quota_R2: assert property (@(posedge clk) disable iff (rst)
    drain_q |-> (task_cnt >= thr_q));

  // R7: the done indication lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: the default path never asks threads to drain
  assert_default_no_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (fb_q && done_q) |-> !drain_q);

  // R9: a start during a running interval leaves the threshold alone
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start) |=> (thr_q == $past(thr_q)));
endmodule

// File: tb/cpt_monitor_tb.sv
module cpt_monitor_tb;
  localparam int CYC_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  active_threads = '0;
  logic [15:0] loop_tasks = '0;
  logic        task_done = 1'b0;
  logic        all_idle = 1'b0;
  logic        drain_req, interval_done, use_default;
  logic [15:0] cycles_per_task;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cpt_monitor u_dut (
    .clk(clk), .rst(rst), .start(start), .active_threads(active_threads),
    .loop_tasks(loop_tasks), .task_done(task_done), .all_idle(all_idle),
    .drain_req(drain_req), .interval_done(interval_done),
    .use_default(use_default), .cycles_per_task(cycles_per_task)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic open_iv(input int th, input int lt);
    @(negedge clk);
    start = 1'b1; active_threads = 4'(th); loop_tasks = 16'(lt);
    @(negedge clk);
    start = 1'b0;
  endtask

  // One full interval; expected values come from the requirement arithmetic
  task automatic run_iv(input int th, input int gap, input int extra,
                        input bit last_td, input bit busy_start, input int lt);
    int n = 0;
    int tasks = 0;
    int thr = 2 * th;
    open_iv(th, lt);
    chk("R8 use_default cleared", use_default, 0);
    while (tasks < thr) begin
      chk("R2 drain low below quota", drain_req, 0);
      task_done = ((n % gap) == gap - 1);
      all_idle  = (n == 0);                 // R5: idle seen while running
      start     = busy_start && (n == 1);   // R9: stray start
      if (start) active_threads = 4'd15;
      @(posedge clk);
      n++;
      if (task_done) tasks++;
      @(negedge clk);
      task_done = 1'b0; all_idle = 1'b0; start = 1'b0;
    end
    chk("R2 drain after quota", drain_req, 1);
    for (int k = 0; k < extra; k++) begin
      task_done = 1'b1;
      @(posedge clk); n++; tasks++;
      @(negedge clk); task_done = 1'b0;
      chk("R3 drain held", drain_req, 1);
    end
    all_idle = 1'b1; task_done = last_td;   // R3: same-cycle final task
    @(posedge clk); n++; if (last_td) tasks++;
    @(negedge clk); all_idle = 1'b0; task_done = 1'b0;
    chk("R3 drain released", drain_req, 0);
    for (int k = 2; k <= CYC_W + 1; k++) begin
      @(negedge clk);
      chk("R7 done not early", interval_done, 0);
    end
    @(negedge clk);
    chk("R7 done on time", interval_done, 1);
    chk("R4 R6 cycles per task", cycles_per_task, n / tasks);
    @(negedge clk);
    chk("R7 done single cycle", interval_done, 0);
  endtask

  task automatic run_dflt(input int th, input int lt);
    open_iv(th, lt);
    chk("R8 default done", interval_done, 1);
    chk("R8 default flag", use_default, 1);
    chk("R8 default value", cycles_per_task, 0);
    chk("R8 no drain", drain_req, 0);
    @(negedge clk);
    chk("R8 done single", interval_done, 0);
    chk("R8 flag held", use_default, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 drain reset", drain_req, 0);
    chk("R1 done reset", interval_done, 0);
    chk("R1 default reset", use_default, 0);
    chk("R1 value reset", cycles_per_task, 0);

    for (int th = 1; th <= 8; th++)
      for (int gap = 1; gap <= 3; gap++)
        run_iv(th, gap, th % 3, gap == 2, th == 3, 1000);

    run_dflt(0, 1000);
    run_dflt(4, 239);
    run_iv(4, 2, 1, 1'b1, 1'b0, 240);
    run_dflt(1, 59);
    run_iv(1, 1, 0, 1'b0, 1'b1, 60);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule